// File: doc/BRIEF.md
# Triggered Shutter Sync Generator

This block supplies the horizontal and vertical sync inputs that a CCD timing generator needs, together with an electronic-shutter pulse. It runs from a master clock. Internally it works on a pixel clock enable at half the master rate, so all of its timing advances on every second master cycle. A mode input chooses between two behaviours. In free-run mode the line and frame counters cycle without stopping. In trigger mode an external asynchronous trigger controls the timing: its falling edge phase-resets the counters and starts exactly one frame, and its rising edge fires a shutter pulse that lasts one line period.

The trigger passes through a synchronizer and an edge detector, both clocked by the pixel enable. A restart or a shutter pulse therefore begins on the third pixel tick after the trigger level changes. The trigger must hold each level for at least two pixel ticks to be seen. The clamp and preblank pulses coming back from the timing generator are gated by the frame state. While no frame is running in trigger mode, clamp is suppressed and preblank is forced active. In free-run mode both pass through unchanged.

Top module: `trig_sync_gen`

## Requirements
- R1: `pix_ce` is low in the first cycle after reset and then alternates every master clock. The sync and shutter outputs change only on master edges where `pix_ce` was high, called pixel ticks.
- R2: After reset in trigger mode (`free_run`=0), `hd_out`, `vd_out` and `shutter_out` are low. The frame is idle.
- R3: In trigger mode, a high-to-low trigger change starts a frame on the third pixel tick after the change. On that tick `hd_out` and `vd_out` both go high. Before it, they are unchanged.
- R4: Within a frame, `hd_out` is high for the first HD_WIDTH ticks of each LINE_CLKS-tick line. `vd_out` is high for the first VD_LINES lines of the FRAME_LINES-line frame.
- R5: In trigger mode, a frame lasts LINE_CLKS*FRAME_LINES ticks after it starts. The block then goes idle, with `hd_out` and `vd_out` low, until the next falling trigger edge.
- R6: A falling trigger edge during a running frame restarts it. Line and frame counting return to their first tick.
- R7: In free-run mode, HD and VD run continuously from reset with no gap between frames. Trigger edges do not shift their phase, and no shutter pulse is issued.
- R8: In trigger mode, a low-to-high trigger change raises `shutter_out` on the third pixel tick after the change. It stays high for exactly LINE_CLKS ticks.
- R9: A rising trigger edge while `shutter_out` is high is ignored. The pulse still ends LINE_CLKS ticks after it began.
- R10: In trigger mode, `clamp_out` = `clamp_in` AND frame running, and `pblk_out` = `pblk_in` OR NOT frame running. In free-run mode, both outputs equal their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| free_run | input | 1 | 1 = continuous sync, 0 = trigger mode |
| trig_in | input | 1 | Asynchronous external trigger |
| clamp_in | input | 1 | Clamp pulse from the timing generator |
| pblk_in | input | 1 | Preblank pulse from the timing generator |
| pix_ce | output | 1 | Pixel clock enable, half the master rate |
| hd_out | output | 1 | Horizontal sync to the timing generator |
| vd_out | output | 1 | Vertical sync to the timing generator |
| shutter_out | output | 1 | Electronic-shutter pulse |
| clamp_out | output | 1 | Gated clamp pulse |
| pblk_out | output | 1 | Gated preblank pulse |

## Verification
A corrupted line or frame counter shows up as a shifted or missing `hd_out` edge within one line period. A wrong frame count shows up at the latest when `vd_out` or the idle state fails to appear at the frame boundary. A lost frame-running flag shows up on the same tick as a change in `pblk_out` and `clamp_out`, so the gated pulses expose it earlier than the sync outputs. A shutter counter that reloads or stops early is caught by sampling `shutter_out` on the last tick of its line-long window and on the first tick after it.

// File: rtl/tsg_pkg.sv
package tsg_pkg;

    typedef struct packed {
        logic rise;
        logic fall;
    } trig_edge_t;

    function automatic int cnt_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/tsg_clkdiv.sv
module tsg_clkdiv (
    input  logic clk,
    input  logic rst,
    output logic ce
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= 1'b0;
        else     phase_q <= ~phase_q;
    end

    assign ce = phase_q;
endmodule

// File: rtl/tsg_trig_sync.sv
module tsg_trig_sync
    import tsg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ce,
    input  logic       trig_in,
    output trig_edge_t edges
);
    localparam int DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst)     chain_q <= '0;
        else if (ce) chain_q <= {chain_q[DEPTH-2:0], trig_in};
    end

    assign edges.rise = chain_q[DEPTH-2] & ~chain_q[DEPTH-1];
    assign edges.fall = ~chain_q[DEPTH-2] & chain_q[DEPTH-1];
endmodule

// File: rtl/tsg_frame_timer.sv
module tsg_frame_timer
    import tsg_pkg::*;
#(
    parameter int LINE_CLKS   = 1560,
    parameter int FRAME_LINES = 525,
    parameter int HD_WIDTH    = 116,
    parameter int VD_LINES    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic free_run,
    input  logic restart,
    output logic hd,
    output logic vd,
    output logic active
);
    localparam int HW = cnt_width(LINE_CLKS);
    localparam int VW = cnt_width(FRAME_LINES);
    localparam logic [HW-1:0] H_LAST = HW'(LINE_CLKS - 1);
    localparam logic [VW-1:0] V_LAST = VW'(FRAME_LINES - 1);

    logic [HW-1:0] hcnt_q;
    logic [VW-1:0] vcnt_q;
    logic          arm_q;
    logic          running;
    logic          frame_end;

    assign running   = arm_q | free_run;
    assign frame_end = (hcnt_q == H_LAST) && (vcnt_q == V_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt_q <= '0;
            vcnt_q <= '0;
            arm_q  <= 1'b0;
        end else if (ce) begin
            if (restart && !free_run) begin
                hcnt_q <= '0;
                vcnt_q <= '0;
                arm_q  <= 1'b1;
            end else if (running) begin
                if (hcnt_q == H_LAST) begin
                    hcnt_q <= '0;
                    if (vcnt_q == V_LAST) begin
                        vcnt_q <= '0;
                        arm_q  <= 1'b0;
                    end else begin
                        vcnt_q <= vcnt_q + 1'b1;
                    end
                end else begin
                    hcnt_q <= hcnt_q + 1'b1;
                end
            end else begin
                hcnt_q <= '0;
                vcnt_q <= '0;
            end
        end
    end

    assign hd     = running && (hcnt_q < HW'(HD_WIDTH));
    assign vd     = running && (vcnt_q < VW'(VD_LINES));
    assign active = running;

    // R3: a restart in trigger mode opens line 0, tick 0
    a_r3_restart_opens: assert property (@(posedge clk) disable iff (rst)
        (ce && restart && !free_run) |=> (hd && vd && active));

    // R5: the last tick of a triggered frame is followed by idle
    a_r5_frame_end_idle: assert property (@(posedge clk) disable iff (rst)
        (ce && frame_end && !restart && !free_run) |=> !active);
endmodule

// File: rtl/tsg_shutter.sv
module tsg_shutter
    import tsg_pkg::*;
#(
    parameter int PULSE_TICKS = 1560
) (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic fire,
    output logic active
);
    localparam int SW = cnt_width(PULSE_TICKS + 1);

    logic [SW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (ce) begin
            if (fire && left_q == '0) left_q <= SW'(PULSE_TICKS);
            else if (left_q != '0)    left_q <= left_q - 1'b1;
        end
    end

    assign active = (left_q != '0);

    // R9: a running pulse only counts down, never reloads
    a_r9_no_reload: assert property (@(posedge clk) disable iff (rst)
        (ce && active) |=> (left_q == $past(left_q) - 1'b1));
endmodule

// File: rtl/trig_sync_gen.sv
module trig_sync_gen
    import tsg_pkg::*;
#(
    parameter int LINE_CLKS   = 1560,
    parameter int FRAME_LINES = 525,
    parameter int HD_WIDTH    = 116,
    parameter int VD_LINES    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic free_run,
    input  logic trig_in,
    input  logic clamp_in,
    input  logic pblk_in,
    output logic pix_ce,
    output logic hd_out,
    output logic vd_out,
    output logic shutter_out,
    output logic clamp_out,
    output logic pblk_out
);
    trig_edge_t edges;
    logic       frame_active;
    logic       fire;

    tsg_clkdiv u_div (
        .clk (clk),
        .rst (rst),
        .ce  (pix_ce)
    );

    tsg_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .ce      (pix_ce),
        .trig_in (trig_in),
        .edges   (edges)
    );

    tsg_frame_timer #(
        .LINE_CLKS   (LINE_CLKS),
        .FRAME_LINES (FRAME_LINES),
        .HD_WIDTH    (HD_WIDTH),
        .VD_LINES    (VD_LINES)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .ce       (pix_ce),
        .free_run (free_run),
        .restart  (edges.fall),
        .hd       (hd_out),
        .vd       (vd_out),
        .active   (frame_active)
    );

    assign fire = edges.rise & ~free_run;

    tsg_shutter #(.PULSE_TICKS(LINE_CLKS)) u_shut (
        .clk    (clk),
        .rst    (rst),
        .ce     (pix_ce),
        .fire   (fire),
        .active (shutter_out)
    );

    always_comb begin
        if (free_run) begin
            clamp_out = clamp_in;
            pblk_out  = pblk_in;
        end else begin
            clamp_out = clamp_in & frame_active;
            pblk_out  = pblk_in | ~frame_active;
        end
    end

    // R1: nothing moves on a master edge without the pixel enable
    a_r1_hold_off_tick: assert property (@(posedge clk) disable iff (rst)
        !pix_ce |=> $stable({hd_out, vd_out, shutter_out}));

    // R8: a shutter pulse begins only from a detected rise in trigger mode
    a_r8_shutter_source: assert property (@(posedge clk) disable iff (rst)
        $rose(shutter_out) |-> (!free_run && $past(edges.rise)));
endmodule

// File: tb/trig_sync_gen_test.sv
`timescale 1ns/1ps
module trig_sync_gen_test;
    localparam int LC = 8;
    localparam int FL = 4;
    localparam int HW = 2;
    localparam int VL = 1;
    localparam int NV = 13;

    // offset k after a trigger-mode restart: expected {hd, vd, running, shutter}
    localparam int       VK [NV] = '{0, 1, 2, 4, 5, 7, 8, 10, 16, 24, 31, 32, 40};
    localparam bit [3:0] VE [NV] = '{4'b1111, 4'b1111, 4'b0111, 4'b0111, 4'b0110,
                                     4'b0110, 4'b1010, 4'b0010, 4'b1010, 4'b1010,
                                     4'b0010, 4'b0000, 4'b0000};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic free_run = 1'b0;
    logic trig_in = 1'b0;
    logic clamp_in = 1'b1;
    logic pblk_in = 1'b0;
    logic pix_ce, hd_out, vd_out, shutter_out, clamp_out, pblk_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    trig_sync_gen #(.LINE_CLKS(LC), .FRAME_LINES(FL), .HD_WIDTH(HW), .VD_LINES(VL)) uut (
        .clk(clk), .rst(rst), .free_run(free_run), .trig_in(trig_in),
        .clamp_in(clamp_in), .pblk_in(pblk_in), .pix_ce(pix_ce),
        .hd_out(hd_out), .vd_out(vd_out), .shutter_out(shutter_out),
        .clamp_out(clamp_out), .pblk_out(pblk_out)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // ends on the falling edge just after the next pixel tick
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!pix_ce) @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset(input logic mode);
        rst = 1'b1;
        free_run = mode;
        trig_in = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: got hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int cur;
        // ---- trigger mode, reset state ----
        do_reset(1'b0);
        check("R1 pix_ce low after reset", pix_ce, 1'b0);
        @(negedge clk);
        check("R1 pix_ce toggles high", pix_ce, 1'b1);
        @(negedge clk);
        check("R1 pix_ce toggles low", pix_ce, 1'b0);
        check("R2 hd idle", hd_out, 1'b0);
        check("R2 vd idle", vd_out, 1'b0);
        check("R2 shutter idle", shutter_out, 1'b0);
        check("R10 clamp gated off", clamp_out, 1'b0);
        check("R10 preblank forced", pblk_out, 1'b1);

        // rise now, fall after 3 ticks -> restart lands 3 ticks later
        trig_in = 1'b1;
        tick(2);
        check("R8 shutter not yet", shutter_out, 1'b0);
        tick(1);
        check("R8 shutter starts", shutter_out, 1'b1);
        trig_in = 1'b0;
        tick(2);
        check("R3 hd before restart", hd_out, 1'b0);
        check("R3 vd before restart", vd_out, 1'b0);
        tick(1);

        // ---- table walk over one triggered frame (R3 R4 R5 R8 R10) ----
        cur = 0;
        for (int i = 0; i < NV; i++) begin
            while (cur < VK[i]) begin
                tick(1);
                cur++;
            end
            check("R4 hd in frame", hd_out, VE[i][3]);
            check("R4 vd in frame", vd_out, VE[i][2]);
            check("R10 clamp follows frame", clamp_out, VE[i][1]);
            check("R5 preblank follows idle", pblk_out, ~VE[i][1]);
            check("R8 shutter width", shutter_out, VE[i][0]);
        end

        // ---- R6: restart during a running frame ----
        trig_in = 1'b1;
        tick(2);
        trig_in = 1'b0;
        tick(3);
        check("R6 frame opened", vd_out, 1'b1);
        tick(12);
        trig_in = 1'b1;
        tick(2);
        trig_in = 1'b0;
        tick(2);
        check("R6 vd low mid frame", vd_out, 1'b0);
        tick(1);
        check("R6 vd after restart", vd_out, 1'b1);
        check("R6 hd after restart", hd_out, 1'b1);
        tick(2);
        check("R6 hd phase after restart", hd_out, 1'b0);
        tick(40);
        check("R5 idle after frame", hd_out, 1'b0);

        // ---- R9: rise during an active shutter ----
        trig_in = 1'b1;
        tick(3);
        check("R9 first pulse on", shutter_out, 1'b1);
        trig_in = 1'b0;
        tick(2);
        trig_in = 1'b1;
        tick(5);
        check("R9 pulse last tick", shutter_out, 1'b1);
        tick(1);
        check("R9 no retrigger extension", shutter_out, 1'b0);
        trig_in = 1'b0;
        tick(40);

        // ---- R7: free-run mode ----
        do_reset(1'b1);
        check("R7 hd runs from reset", hd_out, 1'b1);
        check("R7 vd runs from reset", vd_out, 1'b1);
        check("R10 clamp passes", clamp_out, 1'b1);
        pblk_in = 1'b1;
        #1;
        check("R10 preblank passes", pblk_out, 1'b1);
        pblk_in = 1'b0;
        #1;
        check("R10 preblank passes low", pblk_out, 1'b0);
        trig_in = 1'b1;
        tick(2);
        trig_in = 1'b0;
        tick(1);
        check("R7 no shutter in free run", shutter_out, 1'b0);
        tick(2);
        check("R7 trigger no phase reset", hd_out, 1'b0);
        tick(3);
        check("R7 line wraps", hd_out, 1'b1);
        tick(24);
        check("R7 next frame vd", vd_out, 1'b1);
        check("R7 next frame hd", hd_out, 1'b1);
        tick(8);
        check("R7 vd ends", vd_out, 1'b0);
        check("R7 hd continues", hd_out, 1'b1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule